// File: doc/BRIEF.md
# Board Interrupt Aggregator with Register Bank

This block merges sixteen external, level-driven interrupt sources into one active-high interrupt line for the host processor. A source is recorded in a pending register only if its enable bit is already set at the clock edge where the source goes from low to high. The output is raised while any pending bit is also enabled. Software reads the pending register to find the cause. It clears or forces pending bits by rewriting the whole register, and it gates sources with the enable register. In both registers only a fixed set of implemented bit positions can hold a one.

The same register bank holds two card-slot status words and eight plain read/write words for LEDs, switches and miscellaneous board control. In each slot word, bit 5 reports card presence (active low) and follows one dedicated interrupt input. Software can change only the five low control bits of a slot word. A read-only word returns the sampled level of all sixteen inputs, for test. The bus is a single-cycle synchronous interface: a write takes effect at the clock edge where the write enable is high, and read data follows the address combinationally.

Top module: `board_irq_agg`

## Requirements
- R1: `irq_out` is a register. After each clock edge it equals the OR over all bits of (pending AND enable), using the values the two registers take at that same edge. It is low in reset.
- R2: An input that goes from low to high (relative to its level sampled at the previous edge) while its enable bit is set sets its pending bit at that edge. Later deassertion of the input leaves the bit set.
- R3: An input that rises while its enable bit is clear leaves no pending record. Setting the enable bit later, while the input stays high, does not set the pending bit either.
- R4: A write to offset 0xD0 replaces the pending register with write data AND 0x000FEEFF. Enabled rising inputs in the same cycle are ORed in. An input held high does not set its bit again after a clear.
- R5: A write to offset 0xC0 stores write data AND 0x000FEEFF into the enable register. Because enable bits 8 and 12 can never be set, inputs 8 and 12 never become pending.
- R6: Bit 5 of slot word 0 (offset 0xE0) reads the inverse of input 9. Bit 5 of slot word 1 (offset 0xE4) reads the inverse of input 13. Each follows its input one clock later.
- R7: Both slot words read 0x00000420 after reset. A write to a slot word changes only bits [4:0]. Bit 10 stays 1, and all other bits stay as they are.
- R8: Eight plain 32-bit read/write words live at offsets 0x10, 0x14, 0x40, 0x60, 0x80, 0x84, 0x88 and 0x90, each reset to zero.
- R9: Reads of unmapped offsets return zero. Writes to unmapped offsets change no register.
- R10: Offset 0xB0 reads the sixteen input levels sampled at the last clock edge. It is read-only.
- R11: After reset, the pending, enable and plain registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 16 | External interrupt levels |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_out | output | 1 | Aggregated interrupt to the host |

## Verification
The hardest state to reach is an input that is already high when its enable bit is set, or when its pending bit is cleared by software. The correct result is silence: no pending bit and no interrupt. The bench holds an input high across an enable write and across a pending clear, then reads the pending word and `irq_out` a clock later to confirm that nothing was recorded. It drives inputs 8 and 12 with all enable bits written to one, to show that the filtered positions stay quiet.

// File: rtl/board_irq_agg.sv
module board_irq_agg #(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int NIRQ = 16,
  parameter logic [31:0] IMPL = 32'h000FEEFF,
  parameter int CD0 = 9,
  parameter int CD1 = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NIRQ-1:0] irq_in,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_we,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            irq_out
);
  localparam logic [AW-1:0] A_MASK = AW'(8'hC0);
  localparam logic [AW-1:0] A_PEND = AW'(8'hD0);
  localparam logic [AW-1:0] A_SLT0 = AW'(8'hE0);
  localparam logic [AW-1:0] A_SLT1 = AW'(8'hE4);
  localparam logic [AW-1:0] A_LVL  = AW'(8'hB0);
  localparam logic [DW-1:0] IMPL_W = DW'(IMPL);

  logic [NIRQ-1:0] lvl_q;
  logic [DW-1:0]   pend_q, mask_q, pend_n, mask_n, rise;
  logic [4:0]      slot_lo [2];
  logic [DW-1:0]   scr [8];
  logic [2:0]      scr_idx;
  logic            scr_hit;

  wire wr_mask = bus_we && bus_addr == A_MASK;
  wire wr_pend = bus_we && bus_addr == A_PEND;

  assign rise   = DW'(irq_in & ~lvl_q);
  assign mask_n = wr_mask ? (bus_wdata & IMPL_W) : mask_q;
  assign pend_n = (wr_pend ? (bus_wdata & IMPL_W) : pend_q) | (rise & mask_q);

  always_comb begin
    scr_hit = 1'b1;
    scr_idx = 3'd0;
    case (bus_addr)
      AW'(8'h10): scr_idx = 3'd0;
      AW'(8'h14): scr_idx = 3'd1;
      AW'(8'h40): scr_idx = 3'd2;
      AW'(8'h60): scr_idx = 3'd3;
      AW'(8'h80): scr_idx = 3'd4;
      AW'(8'h84): scr_idx = 3'd5;
      AW'(8'h88): scr_idx = 3'd6;
      AW'(8'h90): scr_idx = 3'd7;
      default:    scr_hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q   <= '0;
      pend_q  <= '0;
      mask_q  <= '0;
      irq_out <= 1'b0;
      slot_lo[0] <= '0;
      slot_lo[1] <= '0;
      for (int i = 0; i < 8; i++) scr[i] <= '0;
    end else begin
      lvl_q   <= irq_in;
      pend_q  <= pend_n;
      mask_q  <= mask_n;
      irq_out <= |(pend_n & mask_n);
      if (bus_we && bus_addr == A_SLT0) slot_lo[0] <= bus_wdata[4:0];
      if (bus_we && bus_addr == A_SLT1) slot_lo[1] <= bus_wdata[4:0];
      if (bus_we && scr_hit) scr[scr_idx] <= bus_wdata;
    end
  end

  function automatic logic [DW-1:0] slot_word(input logic [4:0] lo, input logic lvl);
    logic [DW-1:0] w;
    w = '0;
    w[10] = 1'b1;
    w[5] = ~lvl;
    w[4:0] = lo;
    return w;
  endfunction

  always_comb begin
    bus_rdata = '0;
    if (scr_hit) bus_rdata = scr[scr_idx];
    else case (bus_addr)
      A_MASK: bus_rdata = mask_q;
      A_PEND: bus_rdata = pend_q;
      A_SLT0: bus_rdata = slot_word(slot_lo[0], lvl_q[CD0]);
      A_SLT1: bus_rdata = slot_word(slot_lo[1], lvl_q[CD1]);
      A_LVL:  bus_rdata = DW'(lvl_q);
      default: bus_rdata = '0;
    endcase
  end

  logic past_ok;
  always_ff @(posedge clk) past_ok <= rst_n;

  a_r1_out_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> irq_out == |(pend_q & mask_q));
  a_r4_pend_filtered: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & ~IMPL_W) == '0);
  a_r5_mask_filtered: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q & ~IMPL_W) == '0);
  a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !$past(wr_pend) |-> (pend_q & $past(pend_q)) == $past(pend_q));
  a_r3_no_disabled_set: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !$past(wr_pend) |-> (pend_q & ~$past(pend_q) & ~$past(mask_q)) == '0);
  a_r7_slot_hold: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !$past(bus_we) |-> $stable(slot_lo[0]) && $stable(slot_lo[1]));
endmodule

// File: tb/board_irq_agg_test.sv
module board_irq_agg_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_in = '0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  board_irq_agg uut (.clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic set_in(input int i, input logic v);
    @(negedge clk);
    irq_in[i] = v;
    @(negedge clk);
  endtask

  task automatic t_reset;
    rd_chk("R11 pending reset", 8'hD0, 0);
    rd_chk("R11 enable reset", 8'hC0, 0);
    rd_chk("R11 plain reset", 8'h88, 0);
    rd_chk("R7 slot0 reset", 8'hE0, 32'h420);
    rd_chk("R7 slot1 reset", 8'hE4, 32'h420);
    chk("R1 irq reset", irq_out, 0);
  endtask

  task automatic t_plain;
    logic [7:0] offs [8] = '{8'h10, 8'h14, 8'h40, 8'h60, 8'h80, 8'h84, 8'h88, 8'h90};
    for (int i = 0; i < 8; i++) wr(offs[i], 32'hA5000000 + i * 32'h111);
    for (int i = 0; i < 8; i++) rd_chk("R8 plain readback", offs[i], 32'hA5000000 + i * 32'h111);
  endtask

  task automatic t_unmapped;
    wr(8'h20, 32'hDEADBEEF);
    rd_chk("R9 unmapped read", 8'h20, 0);
    rd_chk("R9 neighbour intact", 8'h14, 32'hA5000111);
    rd_chk("R9 pending intact", 8'hD0, 0);
  endtask

  task automatic t_mask;
    wr(8'hC0, 32'hFFFFFFFF);
    rd_chk("R5 enable filtered", 8'hC0, 32'h000FEEFF);
    chk("R1 no pending no irq", irq_out, 0);
    set_in(8, 1); set_in(12, 1);
    rd_chk("R5 inputs 8/12 never pending", 8'hD0, 0);
    chk("R5 irq quiet", irq_out, 0);
    set_in(8, 0); set_in(12, 0);
  endtask

  task automatic t_rise;
    set_in(3, 1);
    rd_chk("R2 pending set", 8'hD0, 32'h8);
    chk("R1 irq raised", irq_out, 1);
    rd_chk("R10 level", 8'hB0, 32'h8);
    set_in(3, 0);
    rd_chk("R2 pending sticky", 8'hD0, 32'h8);
    chk("R2 irq sticky", irq_out, 1);
    wr(8'hD0, 0);
    chk("R4 irq cleared", irq_out, 0);
    rd_chk("R4 pending cleared", 8'hD0, 0);
  endtask

  task automatic t_disabled;
    wr(8'hC0, 0);
    set_in(5, 1);
    rd_chk("R3 no record", 8'hD0, 0);
    wr(8'hC0, 32'h20);
    @(negedge clk);
    rd_chk("R3 late enable no record", 8'hD0, 0);
    chk("R3 irq quiet", irq_out, 0);
    set_in(5, 0);
  endtask

  task automatic t_force;
    wr(8'hC0, 32'hFFFFFFFF);
    wr(8'hD0, 32'hFFFFFFFF);
    rd_chk("R4 forced filtered", 8'hD0, 32'h000FEEFF);
    chk("R1 irq on forced", irq_out, 1);
    wr(8'hC0, 0);
    chk("R1 irq off masked", irq_out, 0);
    wr(8'hD0, 0);
  endtask

  task automatic t_held_clear;
    wr(8'hC0, 32'h4);
    set_in(2, 1);
    chk("R2 irq held input", irq_out, 1);
    wr(8'hD0, 0);
    @(negedge clk);
    rd_chk("R4 held input no reset", 8'hD0, 0);
    chk("R4 irq stays low", irq_out, 0);
    set_in(2, 0);
    wr(8'hC0, 0);
  endtask

  task automatic t_slot;
    set_in(9, 1);
    rd_chk("R6 slot0 present", 8'hE0, 32'h400);
    rd_chk("R6 slot1 untouched", 8'hE4, 32'h420);
    wr(8'hE0, 32'hFFFFFFFF);
    rd_chk("R7 slot0 low bits only", 8'hE0, 32'h41F);
    set_in(9, 0);
    rd_chk("R6 slot0 absent", 8'hE0, 32'h43F);
    set_in(13, 1);
    rd_chk("R6 slot1 present", 8'hE4, 32'h400);
    rd_chk("R10 level 13", 8'hB0, 32'h2000);
    wr(8'hE4, 32'hFFFFFFEA);
    rd_chk("R7 slot1 write", 8'hE4, 32'h40A);
    wr(8'hB0, 32'hFFFF);
    rd_chk("R10 read-only", 8'hB0, 32'h2000);
    set_in(13, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_unmapped();
    t_mask();
    t_rise();
    t_disabled();
    t_force();
    t_held_clear();
    t_slot();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule